// File: doc/BRIEF.md
# Compare-Match Toggle Timer

This block is a single-channel timer that generates a square-wave-like output. A 24-bit up-counter advances on a timer-clock qualifier, `tick`. That qualifier is produced outside the block, for example by a divide-by-two stage or a prescaler. Whenever the counter steps onto the programmed compare value, the output pin inverts and a sticky match flag is raised. The flag can also drive an interrupt request.

Software uses a small register port to program a start value, a compare value and a control word. When the timer starts, the counter is loaded with the start value and the pin takes a programmable initial level. After each match, the counter either reloads the start value on the following tick, which gives a fixed period, or keeps counting. In the second case it wraps from all-ones to zero. The toggle function runs only while the enable bit is set and the mode field selects toggle operation.

The register port is a plain strobe interface with no back-pressure. A write takes effect at the clock edge where `wr_en` is high. A read is combinational from `rd_addr`. There is no streaming data path, so no valid/ready handshake is needed.

Top module: `tgt_toggle_timer`

## Requirements
- R1: The timer runs only while enable (control bit 4) is 1 and the mode field (control bits 3..0) equals 4'b0010. With any other mode value the counter and pin hold, even when `tick` pulses.
- R2: One clock after the timer becomes running, the counter holds the start value (address 1) and `toggle_out` equals the invert bit (control bit 5). A tick in that start cycle is ignored.
- R3: While running, a clock with `tick` high advances the counter by one. A clock with `tick` low leaves it unchanged.
- R4: A tick that steps the counter onto the compare value (address 2) inverts `toggle_out` at that same edge. Apart from a start, `toggle_out` changes at no other time.
- R5: A match sets the flag (control bit 8 on read). Writing control with bit 8 = 1 clears the flag. If a match and such a clear occur at the same edge, the flag ends set.
- R6: `irq` is high exactly when the flag is 1 and interrupt-enable (control bit 7) is 1.
- R7: With reload (control bit 6) set at the match, the next tick loads the start value instead of incrementing, and that tick never counts as a match.
- R8: With reload clear, counting continues past the compare value and wraps from 24'hFFFFFF to 0.
- R9: When enable is cleared, the counter, `toggle_out` and the flag keep their values.
- R10: Address map: 0 = control/status, 1 = start value, 2 = compare value, 3 = counter (read-only). Reads return the stored values, zero-extended.
- R11: After reset, all registers, the counter, the flag, `toggle_out` and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timer-clock qualifier, one cycle per timer period |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 24 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 24 | Register read data (combinational) |
| toggle_out | output | 1 | Toggle output pin |
| irq | output | 1 | Compare interrupt request |

## Verification
The assertions assume that `tick`, `wr_en` and every address and data input are known and stable around each rising clock edge once reset is released. They also assume that `tick` is a one-cycle qualifier rather than a separate clock. The stimulus meets these assumptions by changing every input only at falling edges and by holding reset low for several cycles first. In the random phase, start and compare values are mostly kept below 64 so that matches, reloads and flag clears collide often. Directed cases cover the counter wrap, the set-over-clear collision and the non-toggle mode.

// File: rtl/tgt_pkg.sv
package tgt_pkg;
  localparam int CTRL_BITS = 8;   // stored control fields
  localparam int FLAG_BIT  = 8;   // sticky match flag position on read
  localparam logic [3:0] MODE_TOGGLE = 4'b0010;

  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_LOAD = 2'd1,
    A_CMP  = 2'd2,
    A_CNT  = 2'd3
  } addr_e;

  // bit 7 down to bit 0
  typedef struct packed {
    logic       ien;
    logic       rld;
    logic       inv;
    logic       en;
    logic [3:0] mode;
  } ctrl_t;
endpackage

// File: rtl/tgt_regs.sv
module tgt_regs
  import tgt_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              match,
  output ctrl_t             ctrl,
  output logic [DATA_W-1:0] load_val,
  output logic [DATA_W-1:0] cmp_val,
  output logic              flag
);
  ctrl_t             ctrl_q;
  logic [DATA_W-1:0] load_q;
  logic [DATA_W-1:0] cmp_q;
  logic              flag_q;
  logic              ctrl_wr;
  logic              flag_clr;

  assign ctrl_wr  = wr_en && (addr_e'(wr_addr) == A_CTRL);
  assign flag_clr = ctrl_wr && wr_data[FLAG_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      load_q <= '0;
      cmp_q  <= '0;
    end else if (wr_en) begin
      case (addr_e'(wr_addr))
        A_CTRL:  ctrl_q <= ctrl_t'(wr_data[CTRL_BITS-1:0]);
        A_LOAD:  load_q <= wr_data;
        A_CMP:   cmp_q  <= wr_data;
        default: ;
      endcase
    end
  end

  // a set from a match wins over a same-cycle software clear
  always_ff @(posedge clk) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= match | (flag_q & ~flag_clr);
  end

  assign ctrl     = ctrl_q;
  assign load_val = load_q;
  assign cmp_val  = cmp_q;
  assign flag     = flag_q;
endmodule

// File: rtl/tgt_count.sv
module tgt_count #(
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              start,
  input  logic              tick,
  input  logic              reload_mode,
  input  logic [DATA_W-1:0] load_val,
  input  logic [DATA_W-1:0] cmp_val,
  output logic [DATA_W-1:0] count,
  output logic              match,
  output logic              pend
);
  localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

  logic [DATA_W-1:0] count_q;
  logic [DATA_W-1:0] count_inc;
  logic              pend_q;
  logic              step;

  assign count_inc = count_q + ONE;
  assign step      = run && !start && tick;
  // only an increment step can land on the compare value
  assign match     = step && !pend_q && (count_inc == cmp_val);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
      pend_q  <= 1'b0;
    end else if (start) begin
      count_q <= load_val;
      pend_q  <= 1'b0;
    end else if (step) begin
      if (pend_q) begin
        count_q <= load_val;
        pend_q  <= 1'b0;
      end else begin
        count_q <= count_inc;
        pend_q  <= match && reload_mode;
      end
    end
  end

  assign count = count_q;
  assign pend  = pend_q;
endmodule

// File: rtl/tgt_pin.sv
module tgt_pin (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic match,
  input  logic inv,
  output logic pin
);
  logic pin_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     pin_q <= 1'b0;
    else if (start) pin_q <= inv;
    else if (match) pin_q <= ~pin_q;
  end

  assign pin = pin_q;
endmodule

// File: rtl/tgt_toggle_timer.sv
module tgt_toggle_timer
  import tgt_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              toggle_out,
  output logic              irq
);
  localparam int PAD_W = DATA_W - FLAG_BIT - 1;

  ctrl_t             ctrl;
  logic [DATA_W-1:0] load_val;
  logic [DATA_W-1:0] cmp_val;
  logic [DATA_W-1:0] count;
  logic              flag;
  logic              match;
  logic              pend;
  logic              run;
  logic              run_prev;
  logic              start;
  logic              inv_bit;
  logic              ien_bit;

  tgt_regs #(.DATA_W(DATA_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .match    (match),
    .ctrl     (ctrl),
    .load_val (load_val),
    .cmp_val  (cmp_val),
    .flag     (flag)
  );

  assign inv_bit = ctrl.inv;
  assign ien_bit = ctrl.ien;
  assign run     = ctrl.en && (ctrl.mode == MODE_TOGGLE);

  always_ff @(posedge clk) begin
    if (!rst_n) run_prev <= 1'b0;
    else        run_prev <= run;
  end

  assign start = run && !run_prev;

  tgt_count #(.DATA_W(DATA_W)) u_count (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (run),
    .start       (start),
    .tick        (tick),
    .reload_mode (ctrl.rld),
    .load_val    (load_val),
    .cmp_val     (cmp_val),
    .count       (count),
    .match       (match),
    .pend        (pend)
  );

  tgt_pin u_pin (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .match (match),
    .inv   (inv_bit),
    .pin   (toggle_out)
  );

  always_comb begin
    case (addr_e'(rd_addr))
      A_CTRL:  rd_data = {{PAD_W{1'b0}}, flag, ctrl};
      A_LOAD:  rd_data = load_val;
      A_CMP:   rd_data = cmp_val;
      default: rd_data = count;
    endcase
  end

  assign irq = flag & ien_bit;
endmodule

// File: rtl/tgt_toggle_timer_chk.sv
module tgt_toggle_timer_chk #(
  parameter int DATA_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              run,
  input logic              start,
  input logic              match,
  input logic              pend,
  input logic [DATA_W-1:0] count,
  input logic [DATA_W-1:0] load_val,
  input logic              inv,
  input logic              flag,
  input logic              pin
);
  // R5
  match_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> flag);

  // R4
  match_flips_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> (pin != $past(pin)));

  // R4
  pin_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!match && !start) |=> $stable(pin));

  // R2
  start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> ((count == $past(load_val)) && (pin == $past(inv))));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(count));

  // R3
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !start && !tick) |=> $stable(count));

  // R8
  step_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !start && tick && !pend) |=> (count == $past(count) + 1'b1));

  // R7
  reload_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !start && tick && pend) |=> (count == $past(load_val)));
endmodule

bind tgt_toggle_timer tgt_toggle_timer_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick     (tick),
  .run      (run),
  .start    (start),
  .match    (match),
  .pend     (pend),
  .count    (count),
  .load_val (load_val),
  .inv      (inv_bit),
  .flag     (flag),
  .pin      (toggle_out)
);

// File: tb/tb_tgt_toggle_timer.sv
`timescale 1ns/1ps
module tb_tgt_toggle_timer;
  localparam int W = 24;
  localparam logic [W-1:0] MASK = '1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         tick = 1'b0;
  logic         wr_en = 1'b0;
  logic [1:0]   wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic [1:0]   rd_addr = '0;
  logic [W-1:0] rd_data;
  logic         toggle_out;
  logic         irq;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  tgt_toggle_timer #(.DATA_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .toggle_out(toggle_out), .irq(irq)
  );

  // reference model built from the requirements
  logic [3:0]   m_mode;
  logic         m_en, m_inv, m_rld, m_ien, m_flag, m_out, m_pend, m_rprev;
  logic [W-1:0] m_load, m_cmp, m_cnt;

  always @(posedge clk) begin : model
    logic run, strt, mt, clr;
    if (!rst_n) begin
      m_mode = '0; m_en = 0; m_inv = 0; m_rld = 0; m_ien = 0; m_flag = 0;
      m_out = 0; m_pend = 0; m_rprev = 0; m_load = '0; m_cmp = '0; m_cnt = '0;
    end else begin
      run  = m_en && (m_mode == 4'b0010);
      strt = run && !m_rprev;
      mt   = run && !strt && tick && !m_pend && (((m_cnt + 1) & MASK) == m_cmp);
      if (strt) begin
        m_cnt = m_load; m_out = m_inv; m_pend = 0;
      end else if (run && tick) begin
        if (m_pend) begin m_cnt = m_load; m_pend = 0; end
        else begin
          m_cnt = (m_cnt + 1) & MASK;
          if (mt) begin m_out = ~m_out; m_pend = m_rld; end
        end
      end
      clr = wr_en && wr_addr == 2'd0 && wr_data[8];
      m_flag  = mt | (m_flag & ~clr);
      m_rprev = run;
      if (wr_en) begin
        case (wr_addr)
          2'd0: begin
            m_mode = wr_data[3:0]; m_en = wr_data[4]; m_inv = wr_data[5];
            m_rld = wr_data[6]; m_ien = wr_data[7];
          end
          2'd1: m_load = wr_data;
          2'd2: m_cmp  = wr_data;
          default: ;
        endcase
      end
    end
  end

  function automatic logic [W-1:0] mread(input logic [1:0] a);
    case (a)
      2'd0:    return {15'd0, m_flag, m_ien, m_rld, m_inv, m_en, m_mode};
      2'd1:    return m_load;
      2'd2:    return m_cmp;
      default: return m_cnt;
    endcase
  endfunction

  task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [W-1:0] v);
    rd_addr = a;
    #1;
    v = rd_data;
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d, input logic t);
    wr_en = 1; wr_addr = a; wr_data = d; tick = t;
    @(negedge clk);
    wr_en = 0; tick = 0;
  endtask

  task automatic steps(input int n, input logic t);
    tick = t;
    for (int i = 0; i < n; i++) @(negedge clk);
    tick = 0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    logic [W-1:0] v;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst_n = 1;

    // R11 reset state
    rd(2'd3, v); check("R11 counter", v, 0);
    rd(2'd0, v); check("R11 control", v, 0);
    check("R11 pin", {23'd0, toggle_out}, 0);
    check("R11 irq", {23'd0, irq}, 0);

    // R10 map
    wr(2'd1, 24'd5, 0);
    wr(2'd2, 24'd8, 0);
    rd(2'd1, v); check("R10 start value", v, 5);
    rd(2'd2, v); check("R10 compare value", v, 8);
    wr(2'd0, 24'h0F2, 0);           // mode 2, en, inv, reload, ien
    steps(1, 1);                     // start cycle, tick ignored
    rd(2'd3, v); check("R2 counter at start", v, 5);
    check("R2 pin at start", {23'd0, toggle_out}, 1);
    steps(1, 0);
    rd(2'd3, v); check("R3 hold without tick", v, 5);
    steps(2, 1);
    rd(2'd3, v); check("R3 increments", v, 7);
    check("R4 no toggle before match", {23'd0, toggle_out}, 1);
    steps(1, 1);
    check("R4 toggled on match", {23'd0, toggle_out}, 0);
    rd(2'd0, v); check("R5 flag set", {23'd0, v[8]}, 1);
    check("R6 irq high", {23'd0, irq}, 1);
    steps(1, 1);
    rd(2'd3, v); check("R7 reload after match", v, 5);
    check("R7 reload tick no toggle", {23'd0, toggle_out}, 0);
    wr(2'd0, 24'h1F2, 0);
    rd(2'd0, v); check("R5 flag cleared", {23'd0, v[8]}, 0);
    check("R6 irq low", {23'd0, irq}, 0);
    steps(2, 1);                     // counter 7
    wr(2'd0, 24'h1F2, 1);            // match and clear together
    rd(2'd0, v); check("R5 set wins over clear", {23'd0, v[8]}, 1);
    check("R4 second toggle", {23'd0, toggle_out}, 1);
    wr(2'd0, 24'h0F0 & 24'h0E2, 0);  // enable off
    steps(4, 1);
    rd(2'd3, v); check("R9 counter held", v, 8);
    check("R9 pin held", {23'd0, toggle_out}, 1);
    rd(2'd0, v); check("R9 flag held", {23'd0, v[8]}, 1);
    wr(2'd0, 24'h0F3, 0);            // enabled, mode 3
    steps(3, 1);
    rd(2'd3, v); check("R1 other mode holds counter", v, 8);
    check("R1 other mode holds pin", {23'd0, toggle_out}, 1);

    // R8 wrap without reload
    wr(2'd0, 24'h000, 0);
    wr(2'd1, 24'hFFFFFE, 0);
    wr(2'd2, 24'd1, 0);
    wr(2'd0, 24'h092, 0);
    steps(1, 0);
    check("R2 pin takes invert bit 0", {23'd0, toggle_out}, 0);
    steps(2, 1);
    rd(2'd3, v); check("R8 wrap to zero", v, 0);
    steps(1, 1);
    check("R8 toggle at compare", {23'd0, toggle_out}, 1);
    steps(1, 1);
    rd(2'd3, v); check("R8 keeps counting", v, 2);

    // random phase against the reference model
    for (int c = 0; c < 4000; c++) begin
      logic [1:0] a;
      logic [W-1:0] d;
      tick  = ($urandom % 3) != 0;
      wr_en = ($urandom % 10) == 0;
      a = 2'($urandom % 3);
      if (a == 2'd0) begin
        d = {15'd0, 1'($urandom % 4 == 0), 4'($urandom),
             (($urandom % 4) != 0) ? 4'b0010 : 4'($urandom)};
        d[4] = ($urandom % 8) != 0;
      end else begin
        d = (($urandom % 16) == 0) ? W'($urandom) : W'($urandom % 64);
      end
      wr_addr = a; wr_data = d;
      @(negedge clk);
      rd(2'($urandom), v);
      check("R10 random read", v, mread(rd_addr));
      check("R4 random pin", {23'd0, toggle_out}, {23'd0, m_out});
      check("R6 random irq", {23'd0, irq}, {23'd0, m_flag & m_ien});
    end
    wr_en = 0; tick = 0;
    summary();
  end
endmodule